// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a simple UART. Software reaches it over a 32-bit register bus that has two windows. The main window holds a receive data word, a transmit data word and a status word. A second window holds one baud setting word, and that word drives a port of the same name.

On the line side, the block takes received bytes from an external shifter as a byte with a one-cycle strobe. It keeps one byte in a holding register. If a byte arrives while the held byte is still unread, the new byte is discarded and an overrun flag is raised. A transmit write sends one byte to the external shifter as a byte with a one-cycle strobe. Frame error, parity error and transmitter-busy come in from outside and show up live in the status word.

Reads have side effects. Reading the receive word clears the valid flag and the overrun flag. Reading the status word clears only the overrun flag. Parameters set at build time enable the receive path, the transmit path and each of the three interrupt pulses.

Top module: `uart_regfront`

## Requirements
- R1: After a synchronous reset, the held byte, status flags, baud word, transmit strobe and all three interrupt outputs are zero.
- R2: When the receive valid flag is clear and a byte arrives, the byte is stored and status bit 0 (valid) is set. When enabled, `irq_rx` is high for exactly the one cycle that follows the arrival.
- R3: When the receive valid flag is set and a byte arrives, the byte is discarded and the held byte is kept. Status bit 5 (overrun) is set, and when enabled `irq_err` pulses for one cycle.
- R4: A read of main-window byte offset 0x00 returns the held byte in bits 7:0 with zeros above. It then clears both the valid flag and the overrun flag.
- R5: A read of main-window offset 0x08 returns the status word as it stood before the read: bit 0 valid, bit 3 transmitter busy, bit 5 overrun, bit 6 frame error, bit 7 parity error, and zero in all other bits. The read then clears overrun only.
- R6: A write to main-window offset 0x04 raises `tx_strobe` for one cycle with `tx_byte` equal to write data bits 7:0. When enabled, `irq_tx` pulses in the same cycle.
- R7: The baud window word at offset 0x00 is readable and writable, and its value drives `baud_out`.
- R8: An access with any byte enable low, or with address bits 1:0 nonzero, has no effect, and a read of that kind returns zero.
- R9: Reads of unused offsets return zero. Writes to the receive word, the status word or unused offsets change nothing.
- R10: Every read request is answered by `bus_rvalid` high, with `bus_rdata` valid, in the cycle after the request.
- R11: A byte that arrives in the same cycle as a receive-word read is accepted: it is stored and `irq_rx` pulses. The read still returns the previously held byte.
- R12: If a byte arrives while valid is set, in the same cycle as a status read, the overrun flag ends up set.
- R13: With the receive path disabled, arriving bytes change no status bit and raise no interrupt.
- R14: With the transmit path disabled, transmit writes produce no `tx_strobe` and no `irq_tx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window select: 0 = main, 1 = baud |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_be | input | DATA_W/8 | Byte enables; all bits must be high for the access to take effect |
| bus_wdata | input | DATA_W | Write data, little-endian |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rx_stb | input | 1 | Received byte strobe |
| rx_byte | input | BYTE_W | Received byte |
| tx_busy | input | 1 | Transmitter in use, shown in status bit 3 |
| frame_err | input | 1 | Frame error, shown in status bit 6 |
| parity_err | input | 1 | Parity error, shown in status bit 7 |
| tx_strobe | output | 1 | Transmit byte strobe |
| tx_byte | output | BYTE_W | Transmit byte |
| baud_out | output | DATA_W | Baud setting word |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_err | output | 1 | Overrun error interrupt pulse |

## Verification
On every cycle, the assertions check these invariants:
- overrun is never set without valid;
- every receive or error interrupt pulse coincides with the flag it reports;
- a dropped byte leaves the held byte unchanged;
- each transmit strobe, read response and baud change traces back to a bus request in the previous cycle.

The bench scenarios cover what needs a known history:
- the exact values that reads return and clear;
- same-cycle collisions of a byte arrival with a receive read or a status read;
- rejection of partial, misaligned and reserved accesses;
- a second instance built with receive and transmit disabled.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  // main window word indices
  localparam int unsigned WORD_RXDATA = 0;
  localparam int unsigned WORD_TXDATA = 1;
  localparam int unsigned WORD_STATUS = 2;
  // baud window word index
  localparam int unsigned WORD_BAUD   = 0;

  // status bit positions
  localparam int unsigned SB_VALID  = 0;
  localparam int unsigned SB_TXBUSY = 3;
  localparam int unsigned SB_OVR    = 5;
  localparam int unsigned SB_FRAME  = 6;
  localparam int unsigned SB_PARITY = 7;

  typedef struct packed {
    logic rd_any;
    logic rd_rx;
    logic rd_stat;
    logic rd_baud;
    logic wr_tx;
    logic wr_baud;
  } rf_access_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BE_W   = 4
) (
  input  logic              req,
  input  logic              we,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output rf_access_t        acc
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic              full_word;
  logic [WIDX_W-1:0] widx;
  logic              main_ok;
  logic              baud_ok;

  assign full_word = (&be) && (addr[1:0] == 2'b00);
  assign widx      = addr[ADDR_W-1:2];
  assign main_ok   = req && full_word && !win;
  assign baud_ok   = req && full_word && win;

  always_comb begin
    acc         = '0;
    acc.rd_any  = req && !we;
    acc.rd_rx   = main_ok && !we && (widx == WIDX_W'(WORD_RXDATA));
    acc.rd_stat = main_ok && !we && (widx == WIDX_W'(WORD_STATUS));
    acc.wr_tx   = main_ok &&  we && (widx == WIDX_W'(WORD_TXDATA));
    acc.rd_baud = baud_ok && !we && (widx == WIDX_W'(WORD_BAUD));
    acc.wr_baud = baud_ok &&  we && (widx == WIDX_W'(WORD_BAUD));
  end
endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold #(
  parameter int unsigned BYTE_W     = 8,
  parameter bit          RX_EN      = 1'b1,
  parameter bit          IRQ_RX_EN  = 1'b1,
  parameter bit          IRQ_ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_stb,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rd_rx,
  input  logic              rd_stat,
  output logic [BYTE_W-1:0] held_byte,
  output logic              valid,
  output logic              ovr,
  output logic              irq_rx,
  output logic              irq_err
);
  generate
    if (RX_EN) begin : g_rx_on
      logic valid_after_rd;
      logic ovr_after_rd;

      // reads take effect before a same-cycle arrival is judged
      assign valid_after_rd = valid && !rd_rx;
      assign ovr_after_rd   = ovr && !(rd_rx || rd_stat);

      always_ff @(posedge clk) begin
        if (rst) begin
          held_byte <= '0;
          valid     <= 1'b0;
          ovr       <= 1'b0;
          irq_rx    <= 1'b0;
          irq_err   <= 1'b0;
        end else begin
          irq_rx  <= 1'b0;
          irq_err <= 1'b0;
          if (in_stb && !valid_after_rd) begin
            held_byte <= in_byte;
            valid     <= 1'b1;
            ovr       <= ovr_after_rd;
            irq_rx    <= IRQ_RX_EN;
          end else if (in_stb) begin
            valid   <= 1'b1;
            ovr     <= 1'b1;
            irq_err <= IRQ_ERR_EN;
          end else begin
            valid <= valid_after_rd;
            ovr   <= ovr_after_rd;
          end
        end
      end

      assert_ovr_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
        ovr |-> valid);
      assert_irq_rx_flags_valid_R2: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> valid);
      assert_irq_err_flags_ovr_R3: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> ovr);
      assert_drop_keeps_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (in_stb && valid && !rd_rx) |=> $stable(held_byte));
      assert_rx_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !in_stb) |=> (!valid && !ovr));
    end else begin : g_rx_off
      assign held_byte = '0;
      assign valid     = 1'b0;
      assign ovr       = 1'b0;
      assign irq_rx    = 1'b0;
      assign irq_err   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/uart_rf_txport.sv
module uart_rf_txport #(
  parameter int unsigned BYTE_W    = 8,
  parameter bit          TX_EN     = 1'b1,
  parameter bit          IRQ_TX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_tx,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq_tx
);
  generate
    if (TX_EN) begin : g_tx_on
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_strobe <= 1'b0;
          tx_byte   <= '0;
          irq_tx    <= 1'b0;
        end else begin
          tx_strobe <= wr_tx;
          irq_tx    <= wr_tx && IRQ_TX_EN;
          if (wr_tx) tx_byte <= wr_byte;
        end
      end

      assert_tx_strobe_cause_R6: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |-> $past(wr_tx));
      assert_tx_byte_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_tx) |-> $stable(tx_byte));
    end else begin : g_tx_off
      assign tx_strobe = 1'b0;
      assign tx_byte   = '0;
      assign irq_tx    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned BYTE_W     = 8,
  parameter bit          RX_EN      = 1'b1,
  parameter bit          TX_EN      = 1'b1,
  parameter bit          IRQ_RX_EN  = 1'b1,
  parameter bit          IRQ_TX_EN  = 1'b1,
  parameter bit          IRQ_ERR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic                bus_win,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic                rx_stb,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                tx_busy,
  input  logic                frame_err,
  input  logic                parity_err,
  output logic                tx_strobe,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic [DATA_W-1:0]   baud_out,
  output logic                irq_rx,
  output logic                irq_tx,
  output logic                irq_err
);
  localparam int unsigned BE_W = DATA_W / 8;

  rf_access_t         acc;
  logic [BYTE_W-1:0]  held_byte;
  logic               rx_valid;
  logic               rx_ovr;
  logic [DATA_W-1:0]  stat_word;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  baud_q;

  uart_rf_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .req (bus_req),
    .we  (bus_we),
    .win (bus_win),
    .addr(bus_addr),
    .be  (bus_be),
    .acc (acc)
  );

  uart_rf_rxhold #(
    .BYTE_W(BYTE_W), .RX_EN(RX_EN),
    .IRQ_RX_EN(IRQ_RX_EN), .IRQ_ERR_EN(IRQ_ERR_EN)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .in_stb   (rx_stb),
    .in_byte  (rx_byte),
    .rd_rx    (acc.rd_rx),
    .rd_stat  (acc.rd_stat),
    .held_byte(held_byte),
    .valid    (rx_valid),
    .ovr      (rx_ovr),
    .irq_rx   (irq_rx),
    .irq_err  (irq_err)
  );

  uart_rf_txport #(.BYTE_W(BYTE_W), .TX_EN(TX_EN), .IRQ_TX_EN(IRQ_TX_EN)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_tx    (acc.wr_tx),
    .wr_byte  (bus_wdata[BYTE_W-1:0]),
    .tx_strobe(tx_strobe),
    .tx_byte  (tx_byte),
    .irq_tx   (irq_tx)
  );

  always_comb begin
    stat_word            = '0;
    stat_word[SB_VALID]  = rx_valid;
    stat_word[SB_TXBUSY] = tx_busy;
    stat_word[SB_OVR]    = rx_ovr;
    stat_word[SB_FRAME]  = frame_err;
    stat_word[SB_PARITY] = parity_err;
  end

  always_comb begin
    rd_next = '0;
    if (acc.rd_rx)   rd_next[BYTE_W-1:0] = held_byte;
    if (acc.rd_stat) rd_next = stat_word;
    if (acc.rd_baud) rd_next = baud_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      baud_q     <= '0;
    end else begin
      bus_rvalid <= acc.rd_any;
      bus_rdata  <= rd_next;
      if (acc.wr_baud) baud_q <= bus_wdata;
    end
  end

  assign baud_out = baud_q;

  assert_rvalid_cause_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we));
  assert_baud_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(acc.wr_baud) |-> $stable(baud_out));
  assert_partial_no_tx_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(&bus_be)) |=> !tx_strobe);
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              bus_req = 0, bus_we = 0, bus_win = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]        bus_be = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              rx_stb = 0;
  logic [BYTE_W-1:0] rx_byte = '0;
  logic              tx_busy = 0, frame_err = 0, parity_err = 0;

  logic [DATA_W-1:0] rdata, rdata_off, baud_out, baud_off;
  logic              rvalid, rvalid_off;
  logic              tx_strobe, tx_strobe_off;
  logic [BYTE_W-1:0] tx_byte, tx_byte_off;
  logic              irq_rx, irq_tx, irq_err, irq_rx_off, irq_tx_off, irq_err_off;

  uart_regfront u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .bus_rvalid(rvalid), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_busy(tx_busy), .frame_err(frame_err), .parity_err(parity_err),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .baud_out(baud_out),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
  );

  uart_regfront #(.RX_EN(1'b0), .TX_EN(1'b0), .IRQ_RX_EN(1'b0),
                  .IRQ_TX_EN(1'b0), .IRQ_ERR_EN(1'b0)) u_dut_off (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_off), .bus_rvalid(rvalid_off), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_busy(tx_busy), .frame_err(frame_err), .parity_err(parity_err),
    .tx_strobe(tx_strobe_off), .tx_byte(tx_byte_off), .baud_out(baud_off),
    .irq_rx(irq_rx_off), .irq_tx(irq_tx_off), .irq_err(irq_err_off)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive bus fields for one cycle (caller clocks)
  task automatic set_bus(input logic we, input logic win, input logic [ADDR_W-1:0] a,
                         input logic [3:0] be, input logic [31:0] d);
    bus_req = 1; bus_we = we; bus_win = win; bus_addr = a; bus_be = be; bus_wdata = d;
  endtask

  task automatic clr_in();
    bus_req = 0; bus_we = 0; rx_stb = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr_in();
  endtask

  task automatic rd(input logic win, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                    output logic [31:0] d);
    set_bus(0, win, a, be, '0);
    step();
    d = rdata;
  endtask

  task automatic wr(input logic win, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                    input logic [31:0] d);
    set_bus(1, win, a, be, d);
    step();
  endtask

  task automatic send(input logic [7:0] b);
    rx_stb = 1; rx_byte = b;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 tx_strobe", {31'b0, tx_strobe}, 0);
    check("R1 irqs", {29'b0, irq_rx, irq_tx, irq_err}, 0);
    check("R1 baud_out", baud_out, 0);
    rd(0, 4'h8, 4'hF, d);
    check("R1 status", d, 0);
    check("R10 rvalid", {31'b0, rvalid}, 1);
    @(negedge clk);
    check("R10 rvalid drop", {31'b0, rvalid}, 0);
  endtask

  task automatic t_receive_and_overrun();
    logic [31:0] d;
    send(8'hA5);
    check("R2 irq_rx pulse", {31'b0, irq_rx}, 1);
    @(negedge clk);
    check("R2 irq_rx one cycle", {31'b0, irq_rx}, 0);
    rd(0, 4'h8, 4'hF, d);
    check("R2 valid bit", d, 32'h01);
    send(8'h3C);
    check("R3 irq_err pulse", {31'b0, irq_err}, 1);
    check("R3 no irq_rx", {31'b0, irq_rx}, 0);
    rd(0, 4'h8, 4'hF, d);
    check("R5 status with overrun", d, 32'h21);
    rd(0, 4'h8, 4'hF, d);
    check("R5 overrun cleared only", d, 32'h01);
    send(8'h5A);
    rd(0, 4'h0, 4'hF, d);
    check("R3 R4 held byte kept", d, 32'hA5);
    rd(0, 4'h8, 4'hF, d);
    check("R4 read clears valid and overrun", d, 32'h00);
  endtask

  task automatic t_live_status();
    logic [31:0] d;
    tx_busy = 1; frame_err = 1; parity_err = 1;
    rd(0, 4'h8, 4'hF, d);
    check("R5 live bits", d, 32'hC8);
    tx_busy = 0; frame_err = 0; parity_err = 0;
  endtask

  task automatic t_transmit();
    set_bus(1, 0, 4'h4, 4'hF, 32'h1234_56C3);
    @(posedge clk);
    @(negedge clk);
    clr_in();
    check("R6 tx_strobe", {31'b0, tx_strobe}, 1);
    check("R6 tx_byte", {24'b0, tx_byte}, 32'hC3);
    check("R6 irq_tx", {31'b0, irq_tx}, 1);
    check("R14 off no strobe", {30'b0, tx_strobe_off, irq_tx_off}, 0);
    @(negedge clk);
    check("R6 strobe one cycle", {31'b0, tx_strobe}, 0);
  endtask

  task automatic t_baud_and_access();
    logic [31:0] d;
    wr(1, 4'h0, 4'hF, 32'h0000_1B2C);
    check("R7 baud_out", baud_out, 32'h1B2C);
    rd(1, 4'h0, 4'hF, d);
    check("R7 baud readback", d, 32'h1B2C);
    wr(1, 4'h0, 4'h3, 32'hFFFF_FFFF);
    check("R8 partial write ignored", baud_out, 32'h1B2C);
    wr(1, 4'h1, 4'hF, 32'hFFFF_FFFF);
    check("R8 misaligned write ignored", baud_out, 32'h1B2C);
    rd(1, 4'h0, 4'h1, d);
    check("R8 partial read zero", d, 0);
    rd(0, 4'hC, 4'hF, d);
    check("R9 reserved read zero", d, 0);
    rd(0, 4'h4, 4'hF, d);
    check("R9 tx word reads zero", d, 0);
    send(8'h77);
    wr(0, 4'h8, 4'hF, 32'h0);
    wr(0, 4'h0, 4'hF, 32'h0);
    rd(0, 4'h8, 4'hF, d);
    check("R9 writes to status/rx ignored", d, 32'h01);
    set_bus(1, 0, 4'h4, 4'h7, 32'hEE);
    @(posedge clk);
    @(negedge clk);
    clr_in();
    check("R8 partial tx write no strobe", {31'b0, tx_strobe}, 0);
    rd(0, 4'h0, 4'hF, d);
    check("R9 byte intact", d, 32'h77);
  endtask

  task automatic t_collisions();
    logic [31:0] d;
    send(8'h11);
    set_bus(0, 0, 4'h0, 4'hF, '0);
    rx_stb = 1; rx_byte = 8'h22;
    step();
    check("R11 read returns old byte", rdata, 32'h11);
    check("R11 irq_rx", {31'b0, irq_rx}, 1);
    rd(0, 4'h8, 4'hF, d);
    check("R11 valid no overrun", d, 32'h01);
    set_bus(0, 0, 4'h8, 4'hF, '0);
    rx_stb = 1; rx_byte = 8'h33;
    step();
    check("R12 status pre-read", rdata, 32'h01);
    check("R12 irq_err", {31'b0, irq_err}, 1);
    rd(0, 4'h8, 4'hF, d);
    check("R12 overrun stays set", d, 32'h21);
    rd(0, 4'h0, 4'hF, d);
    check("R11 new byte stored", d, 32'h22);
  endtask

  task automatic t_disabled();
    send(8'h99);
    check("R13 off no irq", {30'b0, irq_rx_off, irq_err_off}, 0);
    set_bus(0, 0, 4'h8, 4'hF, '0);
    step();
    check("R13 off status unchanged", rdata_off, 0);
    set_bus(0, 0, 4'h0, 4'hF, '0);
    step();
    check("R13 off rx reads zero", rdata_off, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_receive_and_overrun();
    t_live_status();
    t_transmit();
    t_baud_and_access();
    t_collisions();
    t_disabled();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule